// File: doc/BRIEF.md
# Timestamped Sample Cluster Packer

This block turns a stream of probe samples into the word layout of a logic-capture sample memory. Each cluster takes eight consecutive 16-bit words. The first word is a timestamp, and the next seven are event words. The block sees one event per base clock. When the sample-valid input is low, no word is written, but the event count still advances. A reader can therefore tell from the jump between two cluster timestamps how long the last sample was held.

In the faster rate modes each event carries several sub-samples per probe, so fewer probes fit in one event word. The block places the sub-samples into the event word according to the rate input. It also reports two positions. The first is the next free word address, which is where a capture stopped. The second is the address of the event in which the first trigger pulse arrived. The memory sees two write lanes. One lane writes an event word every valid cycle. The other writes the cluster timestamp in the same cycle as the cluster's first event word.

Top module: `ts_cluster_packer`

## Requirements
- R1: While reset is asserted and after its release, before any event arrives, both write strobes are low, the stop position reads 0 and the trigger-seen flag is low.
- R2: When samp_vld_i is high at a clock edge, exactly one event word write is presented after that edge. When samp_vld_i is low, no event write is presented.
- R3: Words are grouped in clusters of eight, each starting at a multiple of 8. The timestamp sits at the cluster base. The seven events sit at base+1 to base+7 in arrival order. The next cluster follows directly after base+7.
- R4: The timestamp write comes together with the first event word of each cluster. Its value is the number of clock edges since reset, counting invalid ones, at that first event, modulo 2^16.
- R5: rate_i = 0 (base rate, 16 probes): event bit l equals sub_i[l], which is sub-sample 0 of probe l.
- R6: rate_i = 1 (8 probes, 2 sub-samples): event bit l*2+k equals sub_i[k*16+l] for l < 8 and k < 2.
- R7: rate_i = 2 (4 probes, 4 sub-samples): event bit l*4+k equals sub_i[k*16+l] for l < 4 and k < 4.
- R8: rate_i = 3 is reserved and packs exactly as rate_i = 0.
- R9: stop_pos_o always equals the number of words written since reset, which is the next free word address, on 24 bits.
- R10: The first trig_i pulse latches into trig_pos_o the event-word address of the slot current in that cycle, whether or not that cycle carries a sample. It also sets trig_seen_o. Later pulses change neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base event clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_vld_i | input | 1 | This cycle's event carries new samples |
| rate_i | input | 2 | Sub-sample mode: 0 base, 1 double, 2 quad, 3 as base |
| sub_i | input | 64 | Sub-sample vectors, bit k*16+l = sub-sample k of probe l |
| trig_i | input | 1 | Trigger pulse |
| ev_we_o | output | 1 | Event word write strobe |
| ev_addr_o | output | 24 | Event word address |
| ev_data_o | output | 16 | Packed event word |
| ts_we_o | output | 1 | Timestamp write strobe |
| ts_addr_o | output | 24 | Timestamp word address (cluster base) |
| ts_data_o | output | 16 | Timestamp value |
| stop_pos_o | output | 24 | Next free word address |
| trig_pos_o | output | 24 | Event address at the first trigger |
| trig_seen_o | output | 1 | A trigger has been latched |

## Verification
The assertions assume the following about the inputs. Reset is synchronous. sub_i and rate_i may change on any cycle. The memory accepts both lanes in the same cycle, so there is no back-pressure. With no back-pressure, every valid cycle must step the slot, and a timestamp can never appear in two cycles in a row. The stimulus drives only legal two-bit rate codes, including the reserved one. It mixes runs with valid density from sparse to full. It sends rare trigger pulses, some on invalid cycles. It also includes one long idle stretch, so the 16-bit timestamp wraps while no word address moves.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
   typedef enum logic [1:0] {
      RATE_BASE = 2'd0,
      RATE_X2   = 2'd1,
      RATE_X4   = 2'd2,
      RATE_RSV  = 2'd3
   } rate_e;
endpackage

// File: rtl/cpk_interleave.sv
module cpk_interleave
   import cpk_pkg::*;
#(
   parameter int NPROBE = 16,
   parameter int MAXSUB = 4
) (
   input  logic [1:0]               rate_i,
   input  logic [MAXSUB*NPROBE-1:0] sub_i,
   output logic [NPROBE-1:0]        word_o
);
   localparam int NMODE = $clog2(MAXSUB) + 1;

   if (MAXSUB != 1 && MAXSUB != 2 && MAXSUB != 4) begin : g_bad_sub
      $error("MAXSUB must be 1, 2 or 4");
   end
   if (NPROBE % MAXSUB != 0) begin : g_bad_probe
      $error("NPROBE must be a multiple of MAXSUB");
   end

   logic [NMODE-1:0][NPROBE-1:0] lanes;

   for (genvar g = 0; g < NMODE; g++) begin : g_mode
      localparam int S = 1 << g;
      for (genvar l = 0; l < NPROBE / S; l++) begin : g_probe
         for (genvar k = 0; k < S; k++) begin : g_sub
            assign lanes[g][l*S+k] = sub_i[k*NPROBE+l];
         end
      end
   end

   always_comb begin
      word_o = lanes[0];
      if (rate_i == RATE_X2 && NMODE > 1) word_o = lanes[(NMODE > 1) ? 1 : 0];
      if (rate_i == RATE_X4 && NMODE > 2) word_o = lanes[(NMODE > 2) ? 2 : 0];
   end
endmodule

// File: rtl/cpk_tracker.sv
module cpk_tracker #(
   parameter int ADDR_W     = 24,
   parameter int EVT_PER_CL = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic              trig_i,
   output logic              first_o,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] ev_addr_o,
   output logic [ADDR_W-1:0] stop_pos_o,
   output logic [ADDR_W-1:0] trig_pos_o,
   output logic              trig_seen_o
);
   localparam int SLOT_W   = $clog2(EVT_PER_CL);
   localparam int CL_WORDS = EVT_PER_CL + 1;
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(EVT_PER_CL - 1);

   if (EVT_PER_CL < 2) begin : g_bad_evt
      $error("EVT_PER_CL must be at least 2");
   end

   logic [SLOT_W-1:0] slot_q;
   logic [ADDR_W-1:0] base_q;

   assign first_o    = (slot_q == '0);
   assign base_o     = base_q;
   assign ev_addr_o  = base_q + ADDR_W'(slot_q) + ADDR_W'(1);
   assign stop_pos_o = first_o ? base_q : ev_addr_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
         base_q <= '0;
      end else if (vld_i) begin
         if (slot_q == LAST) begin
            slot_q <= '0;
            base_q <= base_q + ADDR_W'(CL_WORDS);
         end else begin
            slot_q <= slot_q + SLOT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_seen_o <= 1'b0;
         trig_pos_o  <= '0;
      end else if (trig_i && !trig_seen_o) begin
         trig_seen_o <= 1'b1;
         trig_pos_o  <= ev_addr_o;
      end
   end

   AST_TRIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      trig_seen_o |=> (trig_seen_o && $stable(trig_pos_o))); // R10
   AST_STOP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_pos_o - $past(stop_pos_o)) <= ADDR_W'(2)); // R9
endmodule

// File: rtl/ts_cluster_packer.sv
module ts_cluster_packer
   import cpk_pkg::*;
#(
   parameter int NPROBE     = 16,
   parameter int MAXSUB     = 4,
   parameter int ADDR_W     = 24,
   parameter int TS_W       = 16,
   parameter int EVT_PER_CL = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     samp_vld_i,
   input  logic [1:0]               rate_i,
   input  logic [MAXSUB*NPROBE-1:0] sub_i,
   input  logic                     trig_i,
   output logic                     ev_we_o,
   output logic [ADDR_W-1:0]        ev_addr_o,
   output logic [NPROBE-1:0]        ev_data_o,
   output logic                     ts_we_o,
   output logic [ADDR_W-1:0]        ts_addr_o,
   output logic [TS_W-1:0]          ts_data_o,
   output logic [ADDR_W-1:0]        stop_pos_o,
   output logic [ADDR_W-1:0]        trig_pos_o,
   output logic                     trig_seen_o
);
   localparam int CL_WORDS = EVT_PER_CL + 1;

   if (TS_W != NPROBE) begin : g_bad_ts
      $error("timestamp must fill one memory word");
   end

   logic [NPROBE-1:0] packed_word;
   logic              first;
   logic [ADDR_W-1:0] base, cur_addr;
   logic [TS_W-1:0]   evt_q;

   cpk_interleave #(.NPROBE(NPROBE), .MAXSUB(MAXSUB)) u_ilv (
      .rate_i (rate_i),
      .sub_i  (sub_i),
      .word_o (packed_word)
   );

   cpk_tracker #(.ADDR_W(ADDR_W), .EVT_PER_CL(EVT_PER_CL)) u_trk (
      .clk         (clk),
      .rst_n       (rst_n),
      .vld_i       (samp_vld_i),
      .trig_i      (trig_i),
      .first_o     (first),
      .base_o      (base),
      .ev_addr_o   (cur_addr),
      .stop_pos_o  (stop_pos_o),
      .trig_pos_o  (trig_pos_o),
      .trig_seen_o (trig_seen_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_q     <= '0;
         ev_we_o   <= 1'b0;
         ts_we_o   <= 1'b0;
         ev_addr_o <= '0;
         ev_data_o <= '0;
         ts_addr_o <= '0;
         ts_data_o <= '0;
      end else begin
         evt_q   <= evt_q + TS_W'(1);
         ev_we_o <= samp_vld_i;
         ts_we_o <= samp_vld_i && first;
         if (samp_vld_i) begin
            ev_addr_o <= cur_addr;
            ev_data_o <= packed_word;
         end
         if (samp_vld_i && first) begin
            ts_addr_o <= base;
            ts_data_o <= evt_q;
         end
      end
   end

   AST_VLD_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      samp_vld_i |=> ev_we_o); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_vld_i |=> !ev_we_o); // R2
   AST_EV_OFF_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_we_o |-> (ev_addr_o % CL_WORDS) != 0); // R3
   AST_TS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      ts_we_o |-> (ev_we_o && ev_addr_o == ts_addr_o + ADDR_W'(1))); // R4
   AST_TS_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      ts_we_o |=> !ts_we_o); // R4
endmodule

// File: tb/ts_cluster_packer_tb.sv
module ts_cluster_packer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        samp_vld_i = 1'b0;
   logic [1:0]  rate_i = 2'd0;
   logic [63:0] sub_i = '0;
   logic        trig_i = 1'b0;
   logic        ev_we_o, ts_we_o, trig_seen_o;
   logic [23:0] ev_addr_o, ts_addr_o, stop_pos_o, trig_pos_o;
   logic [15:0] ev_data_o, ts_data_o;

   int n_tests = 0;
   int n_fail  = 0;

   int          m_evt = 0;
   int          m_slot = 0;
   logic [23:0] m_base = '0;
   logic        m_seen = 1'b0;
   logic [23:0] m_tpos = '0;

   always #10 clk = ~clk;

   ts_cluster_packer u_dut (
      .clk(clk), .rst_n(rst_n), .samp_vld_i(samp_vld_i), .rate_i(rate_i),
      .sub_i(sub_i), .trig_i(trig_i), .ev_we_o(ev_we_o), .ev_addr_o(ev_addr_o),
      .ev_data_o(ev_data_o), .ts_we_o(ts_we_o), .ts_addr_o(ts_addr_o),
      .ts_data_o(ts_data_o), .stop_pos_o(stop_pos_o), .trig_pos_o(trig_pos_o),
      .trig_seen_o(trig_seen_o)
   );

   function automatic logic [15:0] exp_word(input logic [1:0] r, input logic [63:0] s);
      logic [15:0] w;
      int n;
      n = (r == 2'd1) ? 2 : (r == 2'd2) ? 4 : 1;
      w = '0;
      for (int p = 0; p < 16 / n; p++)
         for (int k = 0; k < n; k++)
            w[p*n+k] = s[k*16+p];
      return w;
   endfunction

   function automatic string rate_req(input logic [1:0] r);
      case (r)
         2'd1: return "R6";
         2'd2: return "R7";
         2'd3: return "R8";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [1:0] r, input logic [63:0] s, input logic t);
      logic        e_ts;
      logic [23:0] e_addr, e_base, e_stop;
      logic [15:0] e_data, e_tsd;
      samp_vld_i = v; rate_i = r; sub_i = s; trig_i = t;
      e_addr = m_base + 24'(m_slot) + 24'd1;
      e_base = m_base;
      e_data = exp_word(r, s);
      e_ts   = v && (m_slot == 0);
      e_tsd  = 16'(m_evt);
      if (t && !m_seen) begin m_seen = 1'b1; m_tpos = e_addr; end
      if (v) begin
         if (m_slot == 6) begin m_slot = 0; m_base = m_base + 24'd8; end
         else m_slot++;
      end
      m_evt++;
      e_stop = (m_slot == 0) ? m_base : m_base + 24'(m_slot) + 24'd1;
      @(negedge clk);
      chk(ev_we_o == v, "R2", 32'(ev_we_o), 32'(v));
      if (v) begin
         chk(ev_addr_o == e_addr, "R3", 32'(ev_addr_o), 32'(e_addr));
         chk(ev_data_o == e_data, rate_req(r), 32'(ev_data_o), 32'(e_data));
      end
      chk(ts_we_o == e_ts, "R4", 32'(ts_we_o), 32'(e_ts));
      if (e_ts) begin
         chk(ts_data_o == e_tsd, "R4", 32'(ts_data_o), 32'(e_tsd));
         chk(ts_addr_o == e_base, "R3", 32'(ts_addr_o), 32'(e_base));
      end
      chk(stop_pos_o == e_stop, "R9", 32'(stop_pos_o), 32'(e_stop));
      chk(trig_seen_o == m_seen, "R10", 32'(trig_seen_o), 32'(m_seen));
      if (m_seen) chk(trig_pos_o == m_tpos, "R10", 32'(trig_pos_o), 32'(m_tpos));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL R2: watchdog expired, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!ev_we_o && !ts_we_o, "R1", 32'({ev_we_o, ts_we_o}), 0);
      chk(stop_pos_o == 0, "R1", 32'(stop_pos_o), 0);
      chk(!trig_seen_o, "R1", 32'(trig_seen_o), 0);
      rst_n = 1'b1;
      // R1 after release, still no events
      step(1'b0, 2'd0, 64'd0, 1'b0);
      chk(stop_pos_o == 0, "R1", 32'(stop_pos_o), 0);
      // R5 walking ones at base rate, full cluster plus one
      for (int i = 0; i < 8; i++) step(1'b1, 2'd0, 64'd1 << (i * 2), 1'b0);
      // R6 and R7 corner patterns
      step(1'b1, 2'd1, 64'hFFFF_0000_0000_0000, 1'b0);
      step(1'b1, 2'd1, 64'h0000_0000_0001_0080, 1'b0);
      step(1'b1, 2'd2, 64'h0008_0004_0002_0001, 1'b0);
      step(1'b1, 2'd2, 64'h000F_0000_000F_0000, 1'b0);
      // R8 reserved mode
      step(1'b1, 2'd3, 64'hABCD_1234_5678_9ABC, 1'b0);
      // R10 trigger on an invalid cycle, then a second one ignored
      step(1'b0, 2'd0, 64'd0, 1'b1);
      step(1'b1, 2'd0, 64'h1111, 1'b1);
      // R4 gap of idle events before the next cluster
      for (int i = 0; i < 20; i++) step(1'b0, 2'd0, 64'd0, 1'b0);
      for (int i = 0; i < 10; i++) step(1'b1, 2'd2, {$urandom, $urandom}, 1'b0);
      // random mix
      for (int i = 0; i < 3000; i++)
         step(($urandom % 4) != 0, 2'($urandom % 4), {$urandom, $urandom}, ($urandom % 500) == 0);
      // R4 timestamp wrap across a long idle stretch
      for (int i = 0; i < 66000; i++) step(1'b0, 2'd0, 64'd0, 1'b0);
      for (int i = 0; i < 16; i++) step(1'b1, 2'd1, {$urandom, $urandom}, 1'b0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule